// File: doc/BRIEF.md
# Transmit clock failover controller

This block chooses where a line transmit clock comes from. The preferred source is an external transmit clock input. The backup is a clock that follows the system-side transmit clock. Both candidate clocks enter as plain signals. They are synchronised into one fast internal clock and watched for rising edges. A per-clock loss monitor flags a candidate as lost when it goes quiet for too long. The monitor clears that flag only after the clock has shown a run of regular edges again.

When automatic switching is enabled, a lost external clock moves the selection to the backup. When the external clock recovers, the selection moves back on its own. The select that moves depends on the mode. In direct mode it is the output clock select. In oscillator mode it is the reference select of a downstream oscillator. Each select has its own sticky event bit, and a mask input gates the event bits into one interrupt. Clearing the enable sends both selects back to the external clock, even while that clock is lost.

Top module: `txclk_failover`

## Requirements
- R1: After reset, `out_sel` and `ref_sel` are 0 (external clock chosen), `evt_status` is 0 and `irq` is 0.
- R2: A monitored clock (`pri_clk_in` → `pri_lost`, `sys_clk_in` → `sys_lost`) is flagged lost when no rising edge arrives for more than `loss_limit` internal cycles. Edges spaced closer than `loss_limit` cycles never raise the flag.
- R3: A lost flag clears only after `recover_edges` consecutive edge intervals, each shorter than `loss_limit` cycles. A single edge does not clear it.
- R4: With `mode`=0 (direct), `auto_en`=1, `buf_active`=1, `rate_top`=1 and `pri_lost`=1, `out_sel` becomes 1 and `ref_sel` stays 0.
- R5: With `mode`=1 (oscillator), `auto_en`=1, `buf_active`=1 and `pri_lost`=1, `ref_sel` becomes 1 and `out_sel` stays 0. `rate_top` is not required in this mode.
- R6: When `pri_lost` clears while automatic switching is still enabled, the active select returns to 0 with no other input change.
- R7: `auto_en`=0 drives both selects to 0 even while `pri_lost`=1, and a select falling for this reason still sets its event bit.
- R8: No switch to the backup happens while `buf_active`=0. In direct mode, none happens while `rate_top`=0.
- R9: Each change of `out_sel` sets `evt_status[0]`, and each change of `ref_sel` sets `evt_status[1]`. A bit stays set until a one is written to the matching `evt_clr` bit. A set and a clear in the same cycle leave the bit set.
- R10: `irq` is the OR over both bits of `evt_status[i]` AND NOT `irq_mask[i]`. A mask bit of 1 suppresses that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_clk_in | input | 1 | External transmit clock, sampled as a signal |
| sys_clk_in | input | 1 | System-side transmit clock, sampled as a signal |
| loss_limit | input | CNT_W | Loss timeout in internal cycles |
| recover_edges | input | REC_W | Good intervals needed to clear a loss |
| auto_en | input | 1 | Automatic switching enable |
| mode | input | 1 | 0 = direct output switch, 1 = oscillator reference switch |
| buf_active | input | 1 | Transmit elastic buffer is running |
| rate_top | input | 1 | External clock runs at the highest rate for the line mode |
| irq_mask | input | 2 | Per-event interrupt mask, 1 = masked |
| evt_clr | input | 2 | Write-one-to-clear pulses for the event bits |
| out_sel | output | 1 | Output clock select, 1 = backup |
| ref_sel | output | 1 | Oscillator reference select, 1 = backup |
| pri_lost | output | 1 | External clock currently lost |
| sys_lost | output | 1 | System transmit clock currently lost |
| evt_status | output | 2 | Sticky switch events: [0] output select, [1] reference select |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps the default widths (8-bit timeout counter, 3-bit recovery count) and programs `loss_limit`=20 and `recover_edges`=3 through the ports. This makes loss detectable in a few dozen cycles and recovery possible within four edges. Both candidate clocks are driven as slow square waves that the bench can stop and restart. This covers loss and recovery on each monitor, automatic revert, the forced revert on disable, and both blocking conditions within a few hundred cycles per scenario.

// File: rtl/txclk_failover_pkg.sv
package txclk_failover_pkg;

  typedef enum logic {
    SW_DIRECT = 1'b0,
    SW_OSC    = 1'b1
  } sw_mode_e;

  // Saturating idle counter step
  function automatic logic [15:0] idle_step(input logic [15:0] cnt, input logic [15:0] lim);
    return (cnt >= lim) ? cnt : cnt + 16'd1;
  endfunction

  // An interval is good if the edge came before the counter reached the limit
  function automatic logic interval_good(input logic [15:0] cnt, input logic [15:0] lim);
    return cnt < lim;
  endfunction

  // True when one more good interval completes the recovery run
  function automatic logic run_done(input logic [7:0] good, input logic [7:0] need);
    return (good + 8'd1) >= need;
  endfunction

endpackage

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= sig_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
  import txclk_failover_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int REC_W  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [CNT_W-1:0] limit,
  input  logic [REC_W-1:0] need,
  output logic             lost,
  output logic             edge_seen
);
  logic [CNT_W-1:0] idle_q;
  logic [REC_W-1:0] good_q;
  logic             lost_q;
  logic             tmo_hit;
  logic             ivl_ok;
  logic             run_full;
  logic [15:0]      idle_nx;

  clk_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_in(sig_in),
    .rise  (edge_seen)
  );

  assign idle_nx  = idle_step(16'(idle_q), 16'(limit));
  assign tmo_hit  = !edge_seen && (idle_q >= limit);
  assign ivl_ok   = interval_good(16'(idle_q), 16'(limit));
  assign run_full = run_done(8'(good_q), 8'(need));

  always_ff @(posedge clk) begin
    if (!rst_n)         idle_q <= '0;
    else if (edge_seen) idle_q <= '0;
    else                idle_q <= idle_nx[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
      good_q <= '0;
    end else if (!lost_q) begin
      good_q <= '0;
      if (tmo_hit) lost_q <= 1'b1;
    end else if (edge_seen) begin
      if (!ivl_ok) begin
        good_q <= '0;
      end else if (run_full) begin
        lost_q <= 1'b0;
        good_q <= '0;
      end else begin
        good_q <= good_q + 1'b1;
      end
    end
  end

  assign lost = lost_q;

  // R3
  lost_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !edge_seen) |=> lost_q);

  // R2
  no_early_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> !$past(edge_seen));
endmodule

// File: rtl/src_select.sv
module src_select
  import txclk_failover_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pri_lost,
  input  logic auto_en,
  input  logic mode,
  input  logic buf_active,
  input  logic rate_top,
  output logic out_sel,
  output logic ref_sel,
  output logic out_chg,
  output logic ref_chg
);
  sw_mode_e mode_e;
  logic     want_fb;
  logic     out_d;
  logic     ref_d;
  logic     out_q;
  logic     ref_q;

  assign mode_e  = sw_mode_e'(mode);
  assign want_fb = auto_en && buf_active && pri_lost;
  assign out_d   = want_fb && (mode_e == SW_DIRECT) && rate_top;
  assign ref_d   = want_fb && (mode_e == SW_OSC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      out_q <= out_d;
      ref_q <= ref_d;
    end
  end

  assign out_chg = out_d ^ out_q;
  assign ref_chg = ref_d ^ ref_q;
  assign out_sel = out_q;
  assign ref_sel = ref_q;

  // R7
  forced_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (!out_q && !ref_q));

  // R4
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_q && ref_q));

  // R8
  buf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_active |=> (!out_q && !ref_q));
endmodule

// File: rtl/evt_irq.sv
module evt_irq #(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_evt,
  input  logic [N_EVT-1:0] clr_evt,
  input  logic [N_EVT-1:0] mask,
  output logic [N_EVT-1:0] status,
  output logic             irq
);
  logic [N_EVT-1:0] stat_q;

  genvar i;
  generate
    for (i = 0; i < N_EVT; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= set_evt[i] | (stat_q[i] & ~clr_evt[i]);
      end

      // R9
      sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[i] && !clr_evt[i]) |=> stat_q[i]);

      // R9
      set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[i]) |-> $past(set_evt[i]));
    end
  endgenerate

  assign status = stat_q;
  assign irq    = |(stat_q & ~mask);
endmodule

// File: rtl/txclk_failover.sv
module txclk_failover
  import txclk_failover_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int REC_W  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri_clk_in,
  input  logic             sys_clk_in,
  input  logic [CNT_W-1:0] loss_limit,
  input  logic [REC_W-1:0] recover_edges,
  input  logic             auto_en,
  input  logic             mode,
  input  logic             buf_active,
  input  logic             rate_top,
  input  logic [1:0]       irq_mask,
  input  logic [1:0]       evt_clr,
  output logic             out_sel,
  output logic             ref_sel,
  output logic             pri_lost,
  output logic             sys_lost,
  output logic [1:0]       evt_status,
  output logic             irq
);
  localparam int N_EVT = 2;

  logic pri_edge;
  logic sys_edge;
  logic out_chg;
  logic ref_chg;
  logic [N_EVT-1:0] sw_set;

  clk_loss_monitor #(.CNT_W(CNT_W), .REC_W(REC_W), .STAGES(STAGES)) u_pri_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (pri_clk_in),
    .limit    (loss_limit),
    .need     (recover_edges),
    .lost     (pri_lost),
    .edge_seen(pri_edge)
  );

  clk_loss_monitor #(.CNT_W(CNT_W), .REC_W(REC_W), .STAGES(STAGES)) u_sys_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (sys_clk_in),
    .limit    (loss_limit),
    .need     (recover_edges),
    .lost     (sys_lost),
    .edge_seen(sys_edge)
  );

  src_select u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_lost  (pri_lost),
    .auto_en   (auto_en),
    .mode      (mode),
    .buf_active(buf_active),
    .rate_top  (rate_top),
    .out_sel   (out_sel),
    .ref_sel   (ref_sel),
    .out_chg   (out_chg),
    .ref_chg   (ref_chg)
  );

  assign sw_set = {ref_chg, out_chg};

  evt_irq #(.N_EVT(N_EVT)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(sw_set),
    .clr_evt(evt_clr),
    .mask   (irq_mask),
    .status (evt_status),
    .irq    (irq)
  );

  // R9
  out_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel != $past(out_sel)) |-> evt_status[0]);

  // R9
  ref_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != $past(ref_sel)) |-> evt_status[1]);

  // R6
  revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_lost) |=> (!out_sel && !ref_sel));
endmodule

// File: tb/txclk_failover_bench.sv
module txclk_failover_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pri_clk_in = 1'b0;
  logic       sys_clk_in = 1'b0;
  logic [7:0] loss_limit = 8'd20;
  logic [2:0] recover_edges = 3'd3;
  logic       auto_en = 1'b0;
  logic       mode = 1'b0;
  logic       buf_active = 1'b1;
  logic       rate_top = 1'b1;
  logic [1:0] irq_mask = 2'b00;
  logic [1:0] evt_clr = 2'b00;
  logic       out_sel, ref_sel, pri_lost, sys_lost, irq;
  logic [1:0] evt_status;

  int pri_half = 4;
  int sys_half = 5;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txclk_failover u_txclk_failover (
    .clk(clk), .rst_n(rst_n), .pri_clk_in(pri_clk_in), .sys_clk_in(sys_clk_in),
    .loss_limit(loss_limit), .recover_edges(recover_edges), .auto_en(auto_en),
    .mode(mode), .buf_active(buf_active), .rate_top(rate_top), .irq_mask(irq_mask),
    .evt_clr(evt_clr), .out_sel(out_sel), .ref_sel(ref_sel), .pri_lost(pri_lost),
    .sys_lost(sys_lost), .evt_status(evt_status), .irq(irq)
  );

  initial forever begin
    if (pri_half == 0) @(negedge clk);
    else begin
      repeat (pri_half) @(negedge clk);
      pri_clk_in = ~pri_clk_in;
    end
  end

  initial forever begin
    if (sys_half == 0) @(negedge clk);
    else begin
      repeat (sys_half) @(negedge clk);
      sys_clk_in = ~sys_clk_in;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_evt(input logic [1:0] bits);
    @(negedge clk);
    evt_clr = bits;
    @(negedge clk);
    evt_clr = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(2);
    chk("R1 out_sel", out_sel, 0);
    chk("R1 ref_sel", ref_sel, 0);
    chk("R1 evt_status", evt_status, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_loss;
    wait_cyc(100);
    chk("R2 pri running", pri_lost, 0);
    chk("R2 sys running", sys_lost, 0);
    pri_half = 0;
    wait_cyc(40);
    chk("R2 pri stopped", pri_lost, 1);
    chk("R7 no switch while disabled", out_sel, 0);
    pri_half = 4;
    wait_cyc(10);
    chk("R3 one edge not enough", pri_lost, 1);
    wait_cyc(60);
    chk("R3 recovered", pri_lost, 0);
    sys_half = 0;
    wait_cyc(40);
    chk("R2 sys stopped", sys_lost, 1);
    sys_half = 5;
    wait_cyc(70);
    chk("R3 sys recovered", sys_lost, 0);
    chk("R9 no event without switch", evt_status, 0);
  endtask

  task automatic t_direct;
    mode = 1'b0; auto_en = 1'b1; irq_mask = 2'b00;
    pri_half = 0;
    wait_cyc(40);
    chk("R4 out_sel", out_sel, 1);
    chk("R4 ref_sel", ref_sel, 0);
    chk("R9 evt0 set", evt_status, 2'b01);
    chk("R10 irq unmasked", irq, 1);
    wait_cyc(10);
    chk("R9 sticky", evt_status, 2'b01);
    clear_evt(2'b01);
    chk("R9 cleared", evt_status, 0);
    chk("R10 irq low", irq, 0);
    pri_half = 4;
    wait_cyc(70);
    chk("R6 revert", out_sel, 0);
    chk("R9 evt0 on revert", evt_status, 2'b01);
    clear_evt(2'b01);
  endtask

  task automatic t_osc;
    mode = 1'b1; auto_en = 1'b1; rate_top = 1'b0; irq_mask = 2'b10;
    pri_half = 0;
    wait_cyc(40);
    chk("R5 ref_sel", ref_sel, 1);
    chk("R5 out_sel", out_sel, 0);
    chk("R9 evt1 set", evt_status, 2'b10);
    chk("R10 irq masked", irq, 0);
    irq_mask = 2'b00;
    wait_cyc(1);
    chk("R10 irq unmasked", irq, 1);
    clear_evt(2'b10);
    auto_en = 1'b0;
    wait_cyc(3);
    chk("R7 forced primary", ref_sel, 0);
    chk("R7 still lost", pri_lost, 1);
    chk("R7 event on forced", evt_status, 2'b10);
    pri_half = 4;
    wait_cyc(70);
    clear_evt(2'b11);
    rate_top = 1'b1;
  endtask

  task automatic t_block;
    mode = 1'b0; auto_en = 1'b1; rate_top = 1'b0; buf_active = 1'b1;
    pri_half = 0;
    wait_cyc(40);
    chk("R8 rate_top blocks", out_sel, 0);
    chk("R8 no event", evt_status, 0);
    rate_top = 1'b1; buf_active = 1'b0;
    wait_cyc(3);
    chk("R8 buffer blocks", out_sel, 0);
    buf_active = 1'b1;
    wait_cyc(3);
    chk("R4 switch when allowed", out_sel, 1);
    pri_half = 4;
    wait_cyc(70);
    chk("R6 revert again", out_sel, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_loss();
    t_direct();
    t_osc();
    t_block();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule